// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This peripheral is a watchdog timer that sits on a small register bus with a 64-byte window. Once software enables it, it runs down a first preload value and then a second one, with one decrement per prescaler tick. When the second stage expires, the watchdog raises a sticky timeout flag and can emit a one-cycle reset request. The system reset controller consumes that request. The timeout flag is held against the ordinary system reset, so software can still read it after the reboot. Only a power-on reset clears it.

The two preload registers and the reload/status byte are guarded. A write to any of them is accepted only if it comes straight after the key bytes 0x80 and then 0x86, both written to the key offset. Each key opens exactly one such write. A lock bit freezes the enable, the mode bits, the configuration and the preloads until the next reset. Kicks (reloads) and flag clears still work while the lock is set.

Top module: `wdog_unlock_top`

## Requirements
- R1: Writing byte 0x80 and then byte 0x86 to offset 0x0C opens the guard. The next write to a guarded offset is accepted. The guarded offsets are 0x00 (first preload), 0x04 (second preload) and 0x0D (reload/status).
- R2: A write to a guarded offset with the guard closed has no effect. A sequence is broken if the bus write after 0x80 is anything other than 0x86 to 0x0C (a different byte, or a write to another offset). A broken sequence leaves the guard closed, and it expects 0x80 again.
- R3: An open guard is used up by the next bus write of any kind. A second guarded write then needs a fresh key.
- R4: Bit 1 of the lock register (0x18) enables counting. Bit 2 of the configuration register (0x10) selects the tick period: 0 gives 2^FINE_LOG clocks and 1 gives 2^COARSE_LOG clocks. Counting runs first preload + 1 ticks, then second preload + 1 ticks. Expiry therefore happens (P1+P2+2) ticks after the enabling write.
- R5: At expiry, if configuration bit 4 is set, `wdt_rst_req` is high for exactly one cycle. If bit 4 is clear, no pulse is sent, but the timeout flag is still set.
- R6: Reading offset 0x14 returns the current count. While the watchdog is disabled, the count follows the first preload value.
- R7: A guarded write to 0x0D with bit 0 set restarts the countdown from the first preload in stage one and clears the prescaler.
- R8: Bit 1 of 0x0D reads as the timeout flag. Expiry sets it. A guarded write of 1 to bit 1 clears it. It survives `rst_n` and is cleared only by `por_n`.
- R9: `wdt_tmo_pin` is high when the timeout flag is set and configuration bit 5 is set. `wdt_rst_kind` reflects configuration bit 3.
- R10: Once lock bit 0 of 0x18 is set, writes to 0x10, 0x18, 0x00 and 0x04 are ignored until a reset. Guarded writes to 0x0D are still accepted.
- R11: Lock register bit 2 sets what happens after expiry. When it is 0, counting halts at zero until a reload. When it is 1, counting restarts at once from the first preload in stage one.
- R12: Writing 0 to lock bit 1 stops counting, and no expiry follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low, clears everything |
| rst_n | input | 1 | System reset, synchronous, active low, spares the timeout flag |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset in the window, used for both reads and writes |
| bus_wdata | input | 32 | Write data; byte registers use bits 7:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wdt_rst_req | output | 1 | One-cycle reset request at expiry |
| wdt_rst_kind | output | 1 | Reset type select from configuration bit 3 |
| wdt_tmo_pin | output | 1 | Timeout indicator pin |

## Verification
The embedded properties check the following on every cycle:
- the guard opens only on the second key byte and closes after any write;
- prescaler ticks are isolated;
- stage one hands over to the second preload;
- a halted count stays frozen;
- the reset request lasts one cycle;
- the lock really freezes its fields;
- the timeout flag stays set through everything except a clear or a power-on reset.

Only the bench scenarios can show the remaining behaviour:
- end-to-end expiry latency for several preload and prescaler combinations;
- rejection of broken key sequences;
- flag retention across a system reset;
- the auto-restart period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [5:0] OFS_PV1 = 6'h00;
    localparam logic [5:0] OFS_PV2 = 6'h04;
    localparam logic [5:0] OFS_KEY = 6'h0C;
    localparam logic [5:0] OFS_RLD = 6'h0D;
    localparam logic [5:0] OFS_CFG = 6'h10;
    localparam logic [5:0] OFS_CNT = 6'h14;
    localparam logic [5:0] OFS_LCK = 6'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } ul_state_e;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       we,
    input  logic [5:0] addr,
    input  logic [7:0] wbyte,
    output logic       open
);
    typedef struct packed {
        ul_state_e st;
    } ul_t;

    ul_t ul_d, ul_q;
    logic key_a, key_b;

    assign key_a = (addr == OFS_KEY) && (wbyte == KEY_FIRST);
    assign key_b = (addr == OFS_KEY) && (wbyte == KEY_SECOND);

    always_comb begin
        ul_d = ul_q;
        if (we) begin
            case (ul_q.st)
                UL_IDLE: ul_d.st = key_a ? UL_HALF : UL_IDLE;
                UL_HALF: ul_d.st = key_b ? UL_OPEN : UL_IDLE;
                default: ul_d.st = UL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      ul_q <= '{st: UL_IDLE};
        else if (!rst_n) ul_q <= '{st: UL_IDLE};
        else             ul_q <= ul_d;
    end

    assign open = (ul_q.st == UL_OPEN);

    // R1: the guard only opens on the second key byte
    a_r1_open_needs_key: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(open) |-> $past(we && addr == OFS_KEY && wbyte == KEY_SECOND));
    // R3: any write consumes an open guard
    a_r3_single_use: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (open && we) |=> !open);
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int FINE_LOG   = 15,
    parameter int COARSE_LOG = 20
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic coarse,
    output logic tick
);
    localparam int PW = COARSE_LOG;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ps_t;

    ps_t ps_d, ps_q;
    logic fine_hit, coarse_hit;

    assign fine_hit   = &ps_q.cnt[FINE_LOG-1:0];
    assign coarse_hit = &ps_q.cnt[COARSE_LOG-1:0];

    always_comb begin
        ps_d = ps_q;
        if (clear || !run) ps_d.cnt = '0;
        else               ps_d.cnt = ps_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      ps_q <= '0;
        else if (!rst_n) ps_q <= '0;
        else             ps_q <= ps_d;
    end

    assign tick = run && !clear && (coarse ? coarse_hit : fine_hit);

    // R4: ticks are spaced by at least two clocks
    a_r4_tick_isolated: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic             rearm,
    input  logic [CNT_W-1:0] pv1,
    input  logic [CNT_W-1:0] pv2,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stage2;
        logic             halted;
    } dc_t;

    dc_t dc_d, dc_q;

    always_comb begin
        dc_d   = dc_q;
        expire = 1'b0;
        if (!run || restart) begin
            dc_d.cnt    = pv1;
            dc_d.stage2 = 1'b0;
            dc_d.halted = 1'b0;
        end else if (tick && !dc_q.halted) begin
            if (dc_q.cnt != '0) begin
                dc_d.cnt = dc_q.cnt - 1'b1;
            end else if (!dc_q.stage2) begin
                dc_d.cnt    = pv2;
                dc_d.stage2 = 1'b1;
            end else begin
                expire = 1'b1;
                if (rearm) begin
                    dc_d.cnt    = pv1;
                    dc_d.stage2 = 1'b0;
                end else begin
                    dc_d.halted = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      dc_q <= '0;
        else if (!rst_n) dc_q <= '0;
        else             dc_q <= dc_d;
    end

    assign count = dc_q.cnt;

    // R4: an exhausted first stage hands over to the second preload
    a_r4_stage_hand_over: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (run && !restart && tick && !dc_q.halted && dc_q.cnt == '0 && !dc_q.stage2)
        |=> (dc_q.stage2 && dc_q.cnt == $past(pv2)));
    // R11: a halted count does not move until restart or disable
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (dc_q.halted && run && !restart) |=> (dc_q.cnt == $past(dc_q.cnt)));
endmodule

// File: rtl/wdog_unlock_top.sv
module wdog_unlock_top
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int FINE_LOG   = 15,
    parameter int COARSE_LOG = 20
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst_req,
    output logic        wdt_rst_kind,
    output logic        wdt_tmo_pin
);
    localparam int PADW = 32 - CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] pv1;
        logic [CNT_W-1:0] pv2;
        logic             cfg_pre;
        logic             cfg_kind;
        logic             cfg_rsten;
        logic             cfg_pin;
        logic             lk;
        logic             en;
        logic             rearm;
        logic             rst_pulse;
    } top_t;

    top_t st_d, st_q;
    logic tflag_d, tflag_q;
    logic open, guarded, grant, reload, flag_clr, tick, expire;
    logic [CNT_W-1:0] count;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata;

    wdog_unlock u_key (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(bus_we),
        .addr(bus_addr), .wbyte(bus_wdata[7:0]), .open(open)
    );

    wdog_prescale #(.FINE_LOG(FINE_LOG), .COARSE_LOG(COARSE_LOG)) u_pre (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .run(st_q.en),
        .clear(reload), .coarse(st_q.cfg_pre), .tick(tick)
    );

    wdog_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .run(st_q.en),
        .restart(reload), .tick(tick), .rearm(st_q.rearm),
        .pv1(st_q.pv1), .pv2(st_q.pv2), .count(count), .expire(expire)
    );

    assign guarded  = (bus_addr == OFS_PV1) || (bus_addr == OFS_PV2) || (bus_addr == OFS_RLD);
    assign grant    = bus_we && open && guarded;
    assign reload   = grant && (bus_addr == OFS_RLD) && bus_wdata[0];
    assign flag_clr = grant && (bus_addr == OFS_RLD) && bus_wdata[1];

    always_comb begin
        st_d = st_q;
        st_d.rst_pulse = expire && st_q.cfg_rsten;
        if (!st_q.lk) begin
            if (grant && bus_addr == OFS_PV1) st_d.pv1 = bus_wdata[CNT_W-1:0];
            if (grant && bus_addr == OFS_PV2) st_d.pv2 = bus_wdata[CNT_W-1:0];
            if (bus_we && bus_addr == OFS_CFG) begin
                st_d.cfg_pre   = bus_wdata[2];
                st_d.cfg_kind  = bus_wdata[3];
                st_d.cfg_rsten = bus_wdata[4];
                st_d.cfg_pin   = bus_wdata[5];
            end
            if (bus_we && bus_addr == OFS_LCK) begin
                st_d.lk    = bus_wdata[0];
                st_d.en    = bus_wdata[1];
                st_d.rearm = bus_wdata[2];
            end
        end
        tflag_d = tflag_q;
        if (flag_clr) tflag_d = 1'b0;
        if (expire)   tflag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      st_q <= '0;
        else if (!rst_n) st_q <= '0;
        else             st_q <= st_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) tflag_q <= 1'b0;
        else        tflag_q <= tflag_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PV1: bus_rdata = {{PADW{1'b0}}, st_q.pv1};
            OFS_PV2: bus_rdata = {{PADW{1'b0}}, st_q.pv2};
            OFS_RLD: bus_rdata = {30'd0, tflag_q, 1'b0};
            OFS_CFG: bus_rdata = {26'd0, st_q.cfg_pin, st_q.cfg_rsten, st_q.cfg_kind, st_q.cfg_pre, 2'b00};
            OFS_CNT: bus_rdata = {{PADW{1'b0}}, count};
            OFS_LCK: bus_rdata = {29'd0, st_q.rearm, st_q.en, st_q.lk};
            default: bus_rdata = '0;
        endcase
    end

    assign wdt_rst_req  = st_q.rst_pulse;
    assign wdt_rst_kind = st_q.cfg_kind;
    assign wdt_tmo_pin  = tflag_q && st_q.cfg_pin;

    // R5: the reset request lasts a single cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        wdt_rst_req |=> !wdt_rst_req);
    // R10: the lock freezes itself, the enable, the mode, the configuration and the preloads
    a_r10_lock_freezes: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        st_q.lk |=> (st_q.lk && st_q.en == $past(st_q.en) && st_q.rearm == $past(st_q.rearm)
                     && $stable(st_q.pv1) && $stable(st_q.pv2) && st_q.cfg_rsten == $past(st_q.cfg_rsten)
                     && st_q.cfg_pre == $past(st_q.cfg_pre)));
    // R8: only a guarded clear or power-on reset drops the timeout flag
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (tflag_q && !flag_clr) |=> tflag_q);
endmodule

// File: tb/wdog_unlock_top_tb.sv
module wdog_unlock_top_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req, wdt_rst_kind, wdt_tmo_pin;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    wdog_unlock_top #(.CNT_W(20), .FINE_LOG(2), .COARSE_LOG(4)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req), .wdt_rst_kind(wdt_rst_kind), .wdt_tmo_pin(wdt_tmo_pin)
    );

    typedef struct packed {
        logic [7:0]  p1;
        logic [7:0]  p2;
        logic        coarse;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{p1: 8'd0,  p2: 8'd0, coarse: 1'b0, cyc: 16'd8},
        '{p1: 8'd3,  p2: 8'd1, coarse: 1'b0, cyc: 16'd24},
        '{p1: 8'd2,  p2: 8'd5, coarse: 1'b1, cyc: 16'd144},
        '{p1: 8'd10, p2: 8'd0, coarse: 1'b0, cyc: 16'd48},
        '{p1: 8'd0,  p2: 8'd7, coarse: 1'b1, cyc: 16'd144}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pwr(input logic [5:0] a, input logic [31:0] d);
        wr(6'h0C, 32'h80);
        wr(6'h0C, 32'h86);
        wr(a, d);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_pulse(input int max, output int n);
        n = 0;
        while (!wdt_rst_req && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // reset state
        rd(6'h00, v); check("R1 reset preload", v, 0);
        rd(6'h14, v); check("R6 reset count", v, 0);
        rd(6'h18, v); check("R10 reset lock", v, 0);
        rd(6'h0D, v); check("R8 reset flag", v, 0);
        check("R5 reset pulse", {31'd0, wdt_rst_req}, 0);
        check("R9 reset pin", {31'd0, wdt_tmo_pin}, 0);

        // vector table: expiry latency from the enabling write
        foreach (VECS[i]) begin
            wr(6'h18, 0);
            pwr(6'h0D, 32'h2);
            rd(6'h0D, v); check("R8 flag cleared", v, 0);
            pwr(6'h00, {24'd0, VECS[i].p1});
            pwr(6'h04, {24'd0, VECS[i].p2});
            wr(6'h10, {27'd0, 1'b1, 1'b0, VECS[i].coarse, 2'b00});
            wr(6'h18, 32'h2);
            wait_pulse(1000, n);
            check("R4 expiry latency", n, {16'd0, VECS[i].cyc});
            @(negedge clk);
            check("R5 pulse one cycle", {31'd0, wdt_rst_req}, 0);
            rd(6'h0D, v); check("R8 flag set", v, 2);
        end

        // R11 halt after expiry when bit 2 is clear
        wait_pulse(300, n); check("R11 halted no pulse", n, 300);
        rd(6'h14, v); check("R11 halted count", v, 0);

        // R11 auto restart
        wr(6'h18, 0);
        pwr(6'h00, 1);
        pwr(6'h04, 1);
        wr(6'h10, 32'h10);
        wr(6'h18, 32'h6);
        wait_pulse(500, n); check("R4 expiry small", n, 16);
        @(negedge clk);
        wait_pulse(500, n); check("R11 restart period", n, 15);

        // R12 disable
        wr(6'h18, 0);
        wait_pulse(100, n); check("R12 disabled no pulse", n, 100);
        rd(6'h14, v); check("R6 disabled count follows preload", v, 1);

        // R2 guard closed or broken
        wr(6'h00, 5);
        rd(6'h00, v); check("R2 no key", v, 1);
        wr(6'h0C, 32'h80); wr(6'h10, 32'h10); wr(6'h0C, 32'h86); wr(6'h00, 7);
        rd(6'h00, v); check("R2 interrupted key", v, 1);
        wr(6'h0C, 32'h80); wr(6'h0C, 32'h85); wr(6'h0C, 32'h86); wr(6'h00, 7);
        rd(6'h00, v); check("R2 wrong byte", v, 1);

        // R1 and R3
        pwr(6'h00, 9);
        rd(6'h00, v); check("R1 preload1 accepted", v, 9);
        pwr(6'h04, 3);
        rd(6'h04, v); check("R1 preload2 accepted", v, 3);
        wr(6'h04, 4);
        rd(6'h04, v); check("R3 key reused", v, 3);
        wr(6'h0C, 32'h80); wr(6'h0C, 32'h86); wr(6'h10, 32'h10); wr(6'h04, 4);
        rd(6'h04, v); check("R3 key consumed by other write", v, 3);

        // R6 and R7
        wr(6'h18, 32'h2);
        repeat (12) @(negedge clk);
        rd(6'h14, v); check("R6 count readback", v, 6);
        pwr(6'h0D, 1);
        rd(6'h14, v); check("R7 reload value", v, 9);
        repeat (3) @(negedge clk);
        rd(6'h14, v); check("R7 prescaler cleared", v, 9);
        @(negedge clk);
        rd(6'h14, v); check("R7 first tick after reload", v, 8);

        // R8 set, guarded clear, system reset survival
        wait_pulse(200, n); check("R8 expiry seen", {31'd0, wdt_rst_req}, 1);
        @(negedge clk);
        wr(6'h0D, 2);
        rd(6'h0D, v); check("R8 unguarded clear ignored", v, 2);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(6'h0D, v); check("R8 survives rst_n", v, 2);
        rd(6'h18, v); check("R8 rst_n clears lock reg", v, 0);

        // R9 pin and reset kind
        wr(6'h10, 32'h28);
        check("R9 pin on", {31'd0, wdt_tmo_pin}, 1);
        check("R9 kind on", {31'd0, wdt_rst_kind}, 1);
        wr(6'h10, 0);
        check("R9 pin off", {31'd0, wdt_tmo_pin}, 0);
        check("R9 kind off", {31'd0, wdt_rst_kind}, 0);

        // R8 power-on reset clears the flag
        por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        rd(6'h0D, v); check("R8 por clears flag", v, 0);

        // R5 no pulse without reset enable
        wr(6'h18, 32'h2);
        wait_pulse(40, n); check("R5 no pulse when disabled", n, 40);
        rd(6'h0D, v); check("R5 flag still set", v, 2);

        // R10 lock
        wr(6'h18, 32'h3);
        wr(6'h18, 0);
        rd(6'h18, v); check("R10 lock reg frozen", v, 3);
        wr(6'h10, 32'h10);
        rd(6'h10, v); check("R10 cfg frozen", v, 0);
        pwr(6'h00, 5);
        rd(6'h00, v); check("R10 preload frozen", v, 0);
        pwr(6'h0D, 32'h3);
        rd(6'h0D, v); check("R10 reload still accepted", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule